// File: doc/BRIEF.md
# Memory-to-Register Load Sequencer

This block is the hardwired controller for one instruction class of a small accumulator-style datapath: loading a register-file entry from memory. It looks at the opcode and register-index fields of the instruction register, and at a request flag that the decode stage raises. When it is idle, the opcode matches the load code and the flag is set, it steps through a fixed chain of one-cycle states. In that chain it loads the memory address register, drives that register onto the address bus, selects memory for a read, latches the data bus into the memory data register, writes the chosen register-file entry and finally pulses a clear for the request flag.

Every control output comes from a flop and changes only at a clock edge. The register index is captured when the request is taken, so the write-back goes to the entry named at that moment even if the instruction register changes afterwards. The memory address field goes straight from the instruction register into the external address register when the address-load strobe is high. The controller never routes it. The address register, data register, memory, register file and the request-flag register all sit outside this block.

Top module: `ldseq_ctrl`

## Requirements
- R1: While `rst_n` is low, every control output is 0 and the sequencer is idle. After release it stays idle and accepts nothing until `op_req` is set.
- R2: When idle, with `op_req` = 1 and `ir_op` equal to the load opcode (2'b00, instruction bits [7:6]), the next cycle has `mar_ld` high with every other output low. The instruction register must hold its address field (bits [3:0]) through that cycle.
- R3: When idle and either `op_req` = 0 or `ir_op` differs from the load opcode, the next cycle is idle again with all outputs 0.
- R4: The cycle after `mar_ld` has `addr_oe` high alone.
- R5: The cycle after `addr_oe` has `mem_sel` high with `mem_rw` = 0 (read). `mem_rw` is 0 in every cycle.
- R6: The cycle after the read cycle has `mdr_ld` high while `mem_sel` stays high.
- R7: The cycle after `mdr_ld` has `rf_we` high with `mem_sel` low. `rf_sel` equals the register index (instruction bits [5:4]) captured when the request was accepted. `rf_sel` is 0 whenever `rf_we` is low.
- R8: The cycle after `rf_we` has `req_clr` high for exactly one cycle, and the sequencer is idle after that. Changes to `ir_op`, `ir_reg` or `op_req` while a load is running do not alter it.
- R9: In any cycle at most one of `mar_ld`, `addr_oe`, `mdr_ld`, `rf_we`, `req_clr` is high. All outputs are low exactly when the sequencer is idle.
- R10: Once a sequence completes, the register-file entry named at acceptance holds the memory byte at the address named at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| ir_op | input | OP_W (2) | Opcode field of the instruction register |
| ir_reg | input | IDX_W (2) | Register-index field of the instruction register |
| op_req | input | 1 | Decode/operand-fetch request flag |
| mar_ld | output | 1 | Load the address register from the instruction address field |
| addr_oe | output | 1 | Drive the address register onto the address bus |
| mem_sel | output | 1 | Memory chip select |
| mem_rw | output | 1 | Memory direction, 0 = read |
| mdr_ld | output | 1 | Latch the data bus into the data register |
| rf_we | output | 1 | Register-file write enable |
| rf_sel | output | IDX_W (2) | Register-file entry to write |
| req_clr | output | 1 | One-cycle clear for the request flag |

## Verification
The bench builds the block with its defaults: a 2-bit opcode, a 2-bit register index, the load opcode at zero and a two-stage reset synchronizer. That puts all four opcodes within reach, so the three non-load codes can be shown to be ignored, and every register-file entry can be targeted by a write-back. The short synchronizer lets a reset in the middle of a load, and the recovery from it, take only a few cycles. A behavioural address register, memory and register file are driven by the strobes, so each completed load is also checked end to end.

// File: rtl/ldseq_pkg.sv
package ldseq_pkg;

  // Sequencer states; one cycle per non-idle state.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MAR  = 3'd1,
    ST_ADR  = 3'd2,
    ST_RD   = 3'd3,
    ST_MDR  = 3'd4,
    ST_WB   = 3'd5,
    ST_CLR  = 3'd6
  } ldseq_state_e;

  // Single-bit datapath strobes, registered together.
  typedef struct packed {
    logic mar_ld;
    logic addr_oe;
    logic mem_sel;
    logic mem_rw;
    logic mdr_ld;
    logic rf_we;
    logic req_clr;
  } ldseq_strobe_t;

endpackage

// File: rtl/ldseq_next.sv
module ldseq_next
  import ldseq_pkg::*;
#(
  parameter int              OP_W    = 2,
  parameter logic [OP_W-1:0] LOAD_OP = '0
) (
  input  ldseq_state_e    state,
  input  logic [OP_W-1:0] opcode,
  input  logic            req,
  output ldseq_state_e    nxt,
  output logic            accept
);

  always_comb begin
    accept = 1'b0;
    nxt    = state;
    unique case (state)
      ST_IDLE: begin
        if (req && (opcode == LOAD_OP)) begin
          accept = 1'b1;
          nxt    = ST_MAR;
        end
      end
      ST_MAR:  nxt = ST_ADR;
      ST_ADR:  nxt = ST_RD;
      ST_RD:   nxt = ST_MDR;
      ST_MDR:  nxt = ST_WB;
      ST_WB:   nxt = ST_CLR;
      ST_CLR:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ldseq_strobe_dec.sv
module ldseq_strobe_dec
  import ldseq_pkg::*;
(
  input  ldseq_state_e  nxt,
  output ldseq_strobe_t strb
);

  always_comb begin
    strb = '0;
    unique case (nxt)
      ST_MAR:  strb.mar_ld  = 1'b1;
      ST_ADR:  strb.addr_oe = 1'b1;
      ST_RD:   strb.mem_sel = 1'b1;
      ST_MDR: begin
        strb.mem_sel = 1'b1;
        strb.mdr_ld  = 1'b1;
      end
      ST_WB:   strb.rf_we   = 1'b1;
      ST_CLR:  strb.req_clr = 1'b1;
      default: strb = '0;
    endcase
  end

endmodule

// File: rtl/ldseq_ctrl.sv
module ldseq_ctrl
  import ldseq_pkg::*;
#(
  parameter int              OP_W    = 2,
  parameter int              IDX_W   = 2,
  parameter logic [OP_W-1:0] LOAD_OP = '0,
  parameter int              SYNC_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  ir_op,
  input  logic [IDX_W-1:0] ir_reg,
  input  logic             op_req,
  output logic             mar_ld,
  output logic             addr_oe,
  output logic             mem_sel,
  output logic             mem_rw,
  output logic             mdr_ld,
  output logic             rf_we,
  output logic [IDX_W-1:0] rf_sel,
  output logic             req_clr
);

  localparam logic [IDX_W-1:0] SEL_IDLE = '0;

  // Reset: asserted asynchronously, released after SYNC_W clock edges.
  logic rst_int_n;

  generate
    if (SYNC_W <= 1) begin : g_sync1
      logic rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= 1'b0;
        else        rs_q <= 1'b1;
      end
      assign rst_int_n = rs_q;
    end else begin : g_syncn
      logic [SYNC_W-1:0] rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[SYNC_W-2:0], 1'b1};
      end
      assign rst_int_n = rs_q[SYNC_W-1];
    end
  endgenerate

  // Next-state and output decode.
  ldseq_state_e  state_q;
  ldseq_state_e  state_d;
  logic          accept;
  ldseq_strobe_t strb_d;
  ldseq_strobe_t strb_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] sel_d;
  logic [IDX_W-1:0] sel_q;

  ldseq_next #(
    .OP_W    (OP_W),
    .LOAD_OP (LOAD_OP)
  ) u_next (
    .state  (state_q),
    .opcode (ir_op),
    .req    (op_req),
    .nxt    (state_d),
    .accept (accept)
  );

  ldseq_strobe_dec u_dec (
    .nxt  (state_d),
    .strb (strb_d)
  );

  assign sel_d = (state_d == ST_WB) ? idx_q : SEL_IDLE;

  // State register.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  // Register index captured on acceptance (explicit enable).
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  idx_q <= '0;
    else if (accept) idx_q <= ir_reg;
  end

  // Registered Moore strobes.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      strb_q <= '0;
      sel_q  <= SEL_IDLE;
    end else begin
      strb_q <= strb_d;
      sel_q  <= sel_d;
    end
  end

  assign mar_ld  = strb_q.mar_ld;
  assign addr_oe = strb_q.addr_oe;
  assign mem_sel = strb_q.mem_sel;
  assign mem_rw  = strb_q.mem_rw;
  assign mdr_ld  = strb_q.mdr_ld;
  assign rf_we   = strb_q.rf_we;
  assign rf_sel  = sel_q;
  assign req_clr = strb_q.req_clr;

endmodule

// File: rtl/ldseq_chk.sv
module ldseq_chk #(
  parameter int              OP_W    = 2,
  parameter int              IDX_W   = 2,
  parameter logic [OP_W-1:0] LOAD_OP = '0
) (
  input logic             clk,
  input logic             rst_ok_n,
  input logic [OP_W-1:0]  ir_op,
  input logic             op_req,
  input logic             mar_ld,
  input logic             addr_oe,
  input logic             mem_sel,
  input logic             mdr_ld,
  input logic             rf_we,
  input logic [IDX_W-1:0] rf_sel,
  input logic             req_clr
);

  logic busy;
  logic take;
  assign busy = mar_ld | addr_oe | mem_sel | mdr_ld | rf_we | req_clr;
  assign take = op_req && (ir_op == LOAD_OP);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!busy && take) |=> (mar_ld && !addr_oe && !mem_sel && !rf_we && !req_clr));

  assert_ignore_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!busy && !take) |=> !busy);

  assert_adr_after_mar_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    mar_ld |=> (addr_oe && !mar_ld && !mem_sel));

  assert_read_after_adr_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    addr_oe |=> (mem_sel && !mdr_ld && !addr_oe));

  assert_mdr_after_read_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mem_sel && !mdr_ld) |=> (mem_sel && mdr_ld));

  assert_wb_after_mdr_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    mdr_ld |=> (rf_we && !mem_sel && !mdr_ld));

  assert_sel_quiet_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !rf_we |-> (rf_sel == '0));

  assert_clr_after_wb_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rf_we |=> (req_clr && !rf_we));

  assert_idle_after_clr_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    req_clr |=> (!req_clr && !addr_oe && !mem_sel && !mdr_ld && !rf_we));

  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $onehot0({mar_ld, addr_oe, mdr_ld, rf_we, req_clr}));

endmodule

bind ldseq_ctrl ldseq_chk #(
  .OP_W    (OP_W),
  .IDX_W   (IDX_W),
  .LOAD_OP (LOAD_OP)
) u_chk (
  .clk      (clk),
  .rst_ok_n (rst_int_n),
  .ir_op    (ir_op),
  .op_req   (op_req),
  .mar_ld   (mar_ld),
  .addr_oe  (addr_oe),
  .mem_sel  (mem_sel),
  .mdr_ld   (mdr_ld),
  .rf_we    (rf_we),
  .rf_sel   (rf_sel),
  .req_clr  (req_clr)
);

// File: tb/tb_ldseq_ctrl.sv
module tb_ldseq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] ir;
  logic       flag;
  logic       set_req;

  logic       mar_ld, addr_oe, mem_sel, mem_rw, mdr_ld, rf_we, req_clr;
  logic [1:0] rf_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldseq_ctrl dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .ir_op   (ir[7:6]),
    .ir_reg  (ir[5:4]),
    .op_req  (flag),
    .mar_ld  (mar_ld),
    .addr_oe (addr_oe),
    .mem_sel (mem_sel),
    .mem_rw  (mem_rw),
    .mdr_ld  (mdr_ld),
    .rf_we   (rf_we),
    .rf_sel  (rf_sel),
    .req_clr (req_clr)
  );

  int vecs = 0;
  int errs = 0;

  // Expected-sequence model: phase 0 idle, 1..6 the six load steps.
  int         phase;
  logic [1:0] m_idx;
  logic [3:0] m_adr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 0;
      flag  <= 1'b0;
    end else begin
      if (req_clr)      flag <= 1'b0;
      else if (set_req) flag <= 1'b1;
      if (phase == 0) begin
        if (flag && ir[7:6] == 2'b00) begin
          phase <= 1;
          m_idx <= ir[5:4];
          m_adr <= ir[3:0];
        end
      end else if (phase == 6) phase <= 0;
      else                     phase <= phase + 1;
    end
  end

  // Behavioural datapath driven by the strobes.
  logic [3:0] mar, alat;
  logic [7:0] mdr;
  logic [7:0] mem [16];
  logic [7:0] rf  [4];

  always @(posedge clk) begin
    if (mar_ld)                      mar  <= ir[3:0];
    if (addr_oe)                     alat <= mar;
    if (mem_sel && mdr_ld && !mem_rw) mdr <= mem[alat];
    if (rf_we)                       rf[rf_sel] <= mdr;
  end

  function automatic logic [8:0] exp_out(int ph, logic [1:0] idx);
    // {mar_ld, addr_oe, mem_sel, mem_rw, mdr_ld, rf_we, rf_sel[1:0], req_clr}
    case (ph)
      1:       return 9'b1_0_0_0_0_0_00_0;
      2:       return 9'b0_1_0_0_0_0_00_0;
      3:       return 9'b0_0_1_0_0_0_00_0;
      4:       return 9'b0_0_1_0_1_0_00_0;
      5:       return {6'b0_0_0_0_0_1, idx, 1'b0};
      6:       return 9'b0_0_0_0_0_0_00_1;
      default: return 9'b0;
    endcase
  endfunction

  function automatic string tag_of(int ph);
    case (ph)
      1:       return "R2";
      2:       return "R4";
      3:       return "R5";
      4:       return "R6";
      5:       return "R7";
      6:       return "R8";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [8:0] act_out();
    return {mar_ld, addr_oe, mem_sel, mem_rw, mdr_ld, rf_we, rf_sel, req_clr};
  endfunction

  task automatic chk(string rq, logic [8:0] act, logic [8:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%b exp=%b at %0t", rq, act, exp, $time);
    end
  endtask

  // One cycle: compare at the falling edge, then drive new inputs.
  task automatic cyc(logic [7:0] nir, logic nreq);
    @(negedge clk);
    chk(tag_of(phase), act_out(), exp_out(phase, m_idx));
    chk("R9", {8'b0, ($countones({mar_ld, addr_oe, mdr_ld, rf_we, req_clr}) <= 1)}, 9'd1);
    if (phase == 6)
      chk("R10", {1'b0, rf[m_idx]}, {1'b0, mem[m_adr]});
    if (phase != 1) ir = nir;
    set_req = nreq;
  endtask

  task automatic print_summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    errs++;
    $display("FAIL R8 watchdog act=running exp=finished");
    print_summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5E_0A17));
    for (int i = 0; i < 16; i++) mem[i] = 8'((i * 37 + 11) & 8'hFF);
    for (int i = 0; i < 4; i++)  rf[i]  = 8'h00;
    rst_n   = 1'b0;
    ir      = 8'h00;
    set_req = 1'b0;
    m_idx   = 2'b00;
    m_adr   = 4'h0;

    // R1: outputs low in reset
    repeat (3) @(negedge clk);
    chk("R1", act_out(), 9'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) cyc(8'h00, 1'b0);   // R1: idle after release

    // R3: request with non-load opcodes is ignored
    cyc(8'h45, 1'b1);
    for (int op = 1; op < 4; op++)
      for (int k = 0; k < 3; k++) cyc({2'(op), 6'h2A}, 1'b0);
    // R2: switch to the load opcode, flag still set
    cyc(8'h29, 1'b0);
    for (int i = 0; i < 8; i++) cyc(8'h29, 1'b0);

    // R3: load opcode with the flag clear is ignored
    for (int i = 0; i < 5; i++) cyc(8'h00, 1'b0);

    // R8: instruction and request churn during a running load
    cyc(8'h35, 1'b1);
    cyc(8'h35, 1'b0);
    for (int i = 0; i < 7; i++) cyc(8'(8'h0F ^ (i * 8'h13)), 1'b1);
    for (int i = 0; i < 10; i++) cyc(8'hC0, 1'b0);

    // Back-to-back loads with the request held
    for (int i = 0; i < 24; i++) cyc(8'(8'h1C + (i / 9) * 8'h11), 1'b1);
    for (int i = 0; i < 10; i++) cyc(8'h80, 1'b0);

    // R1: reset in the middle of a load
    cyc(8'h2B, 1'b1);
    for (int i = 0; i < 3; i++) cyc(8'h2B, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", act_out(), 9'b0);
    @(negedge clk);
    chk("R1", act_out(), 9'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) cyc(8'h00, 1'b0);

    // Random stimulus
    for (int i = 0; i < 3000; i++)
      cyc(8'($urandom), ($urandom % 4) == 0);
    for (int i = 0; i < 10; i++) cyc(8'hFF, 1'b0);

    print_summary();
    $finish;
  end

endmodule